// File: doc/BRIEF.md
# Indexed-Access Interrupt Controller Front End

This block is the register front end of an interrupt controller that serves a configurable number of sources, up to 128. Each source has its own trigger mode, priority, vector, enable bit, pending latch and fast-force bit. None of these has its own address. Software first writes a source number into an index register. The single mode, vector, enable, disable, clear and set addresses then work only on that source. Pending state is the exception: it is visible for all sources at once, as four 32-bit words.

Behind the registers sits a priority resolver. It checks every implemented source within one cycle against an eight-level nesting stack. A read of the current-vector address acknowledges the winning source, pushes it onto the stack and returns its vector. If nothing is eligible, the same read returns a programmable spurious value. Each end-of-interrupt write pops one level, so eight such writes always empty the stack.

The bus is a simple single-cycle register port. Reads are combinational. Writes and read side effects take place at the rising clock edge.

Top module: `ixc_top`

## Requirements
- R1: The index register at 0x00 stores bits 6:0 of the written data and reads back that value, with bits 31:7 reading 0. A new index applies to the very next bus access.
- R2: Writing data with bit 0 set to the enable address 0x40 sets the enable bit of the indexed source, and the same write to the disable address 0x44 clears it. A write with bit 0 clear does nothing. Bit 0 of the mask address 0x30 reads the enable bit of the indexed source.
- R3: The mode address 0x04 and the vector address 0x08 read and write the indexed source only. The mode word holds the priority in bits 2:0 and the trigger type in bits 6:5: 00 low level, 01 falling edge, 10 high level, 11 rising edge. After reset each mode reads 0x40 (high level, priority 0) and each vector reads 0.
- R4: Pending word k at 0x20+4k has bit j set when source 32k+j is pending. Bits of unimplemented sources always read 0.
- R5: A write with bit 0 set to the set address 0x4C latches the indexed source as pending, and the same write to the clear address 0x48 clears that latch. A write with bit 0 clear does nothing.
- R6: A source in an edge mode latches pending on its chosen input edge, and the latch stays set after the input returns. A source in a level mode is pending exactly while its input is at the active level.
- R7: While the index is at or above the implemented source count, mode, vector and command writes change nothing. In that state the mode, vector, mask and fast-force status addresses read 0.
- R8: irq_out is high exactly when some enabled pending source has a priority above the top of the nesting stack, or the stack is empty. The winner is the highest priority, and among equal priorities the lowest index.
- R9: A read of 0x10 returns the winner's vector, pushes the winner onto the nesting stack and clears its pending latch. With no winner the read returns the spurious value written at 0x3C (reset 0) and changes no state. Address 0x18 reads the index of the source on top of the stack, or 0 when the stack is empty.
- R10: Any write to 0x38 pops one nesting level, and a write on an empty stack has no effect. Eight such writes always leave nothing current.
- R11: Writing data with bit 0 set to 0x50 sets the fast-force bit of the indexed source, and the same write to 0x54 clears it. Bit 0 of 0x58 reads that bit. Fast-force bits have no effect on irq_out or on vectors. Bit 0 of 0x6C is a plain read/write bit.
- R12: The core status at 0x34 reads irq_out in bit 0 and "a source is current" in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe; needed only for reads with side effects |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | NSRC | Interrupt source inputs, synchronous to clk |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
Storage fault symptoms:
- Wrong per-source storage shows at the ports at once: the next mode, vector or mask read of that index returns the wrong value, and a lost edge latch shows in the next pending-word read.
- A wrong decode of the index shows as a neighbouring source changing state.
- An index at or above the source count that still writes shows as a stray pending bit or a non-zero readback.

Resolver and stack fault symptoms:
- A faulty resolver or stack shows as a wrong vector on the acknowledge read, or as irq_out at the wrong level in the cycle after a push or pop.
- The randomized phase, with nested acknowledges over many priority patterns, exposes off-by-one priority comparisons and broken tie-breaks within a few iterations.

// File: rtl/ixc_pkg.sv
package ixc_pkg;
    localparam int MAX_SRC = 128;
    localparam int IDX_W   = 7;

    localparam logic [7:0] A_SEL    = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h04;
    localparam logic [7:0] A_VEC    = 8'h08;
    localparam logic [7:0] A_CURV   = 8'h10;
    localparam logic [7:0] A_FASTV  = 8'h14;
    localparam logic [7:0] A_CURSRC = 8'h18;
    localparam logic [7:0] A_MASK   = 8'h30;
    localparam logic [7:0] A_CORE   = 8'h34;
    localparam logic [7:0] A_EOI    = 8'h38;
    localparam logic [7:0] A_SPUR   = 8'h3C;
    localparam logic [7:0] A_EN     = 8'h40;
    localparam logic [7:0] A_DIS    = 8'h44;
    localparam logic [7:0] A_CLR    = 8'h48;
    localparam logic [7:0] A_SET    = 8'h4C;
    localparam logic [7:0] A_FFEN   = 8'h50;
    localparam logic [7:0] A_FFDIS  = 8'h54;
    localparam logic [7:0] A_FFSTAT = 8'h58;
    localparam logic [7:0] A_DBG    = 8'h6C;

    typedef enum logic [1:0] {
        TRG_LOW  = 2'd0,
        TRG_FALL = 2'd1,
        TRG_HIGH = 2'd2,
        TRG_RISE = 2'd3
    } trig_e;

    typedef struct packed {
        trig_e      trig;
        logic [2:0] prio;
    } mode_t;

    typedef struct packed {
        logic en;
        logic dis;
        logic clr;
        logic set;
        logic ffen;
        logic ffdis;
        logic wmode;
        logic wvec;
    } cmd_t;

    localparam mode_t MODE_RST = '{trig: TRG_HIGH, prio: 3'd0};

    function automatic logic [31:0] mode_to_word(mode_t m);
        return {25'd0, m.trig, 2'b00, m.prio};
    endfunction

    function automatic mode_t word_to_mode(logic [31:0] w);
        mode_t m;
        m.trig = trig_e'(w[6:5]);
        m.prio = w[2:0];
        return m;
    endfunction
endpackage

// File: rtl/ixc_src_bank.sv
module ixc_src_bank
    import ixc_pkg::*;
#(
    parameter int NSRC = 50,
    parameter int VW   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          src_in,
    input  logic [NSRC-1:0]          hit,
    input  cmd_t                     cmd,
    input  logic [31:0]              wdata,
    input  logic [NSRC-1:0]          ack_oh,
    output mode_t [NSRC-1:0]         mode_q,
    output logic [NSRC-1:0][VW-1:0]  vec_q,
    output logic [NSRC-1:0]          en_q,
    output logic [NSRC-1:0]          ff_q,
    output logic [NSRC-1:0]          pend
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        mode_t         m_q;
        logic [VW-1:0] v_q;
        logic          e_q, f_q, prev_q, latch_q;
        logic          edge_ev, lvl_act;

        always_comb begin
            edge_ev = 1'b0;
            lvl_act = 1'b0;
            case (m_q.trig)
                TRG_LOW:  lvl_act = ~src_in[i];
                TRG_HIGH: lvl_act = src_in[i];
                TRG_FALL: edge_ev = prev_q & ~src_in[i];
                TRG_RISE: edge_ev = ~prev_q & src_in[i];
                default:  ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q     <= MODE_RST;
                v_q     <= '0;
                e_q     <= 1'b0;
                f_q     <= 1'b0;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q <= src_in[i];
                if (hit[i] && cmd.wmode) m_q <= word_to_mode(wdata);
                if (hit[i] && cmd.wvec)  v_q <= wdata[VW-1:0];
                if (hit[i] && cmd.en)    e_q <= 1'b1;
                if (hit[i] && cmd.dis)   e_q <= 1'b0;
                if (hit[i] && cmd.ffen)  f_q <= 1'b1;
                if (hit[i] && cmd.ffdis) f_q <= 1'b0;
                if (hit[i] && cmd.clr)
                    latch_q <= 1'b0;
                else if ((hit[i] && cmd.set) || edge_ev)
                    latch_q <= 1'b1;
                else if (ack_oh[i])
                    latch_q <= 1'b0;
            end
        end

        assign mode_q[i] = m_q;
        assign vec_q[i]  = v_q;
        assign en_q[i]   = e_q;
        assign ff_q[i]   = f_q;
        assign pend[i]   = latch_q | lvl_act;

        assert_clr_wins_R5: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && cmd.clr) |=> !latch_q);
        assert_enable_R2: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && cmd.en) |=> e_q);
        assert_edge_latch_R6: assert property (@(posedge clk) disable iff (rst)
            (edge_ev && !(hit[i] && cmd.clr)) |=> latch_q);
        assert_ff_set_R11: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && cmd.ffen) |=> f_q);
    end
endmodule

// File: rtl/ixc_pick.sv
module ixc_pick
    import ixc_pkg::*;
#(
    parameter int NSRC = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req,
    input  mode_t [NSRC-1:0]  mode,
    input  logic              busy,
    input  logic [2:0]        cur_lvl,
    output logic              found,
    output logic [NSRC-1:0]   win_oh,
    output logic [IDX_W-1:0]  win_idx,
    output logic [2:0]        win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!busy || mode[i].prio > cur_lvl) &&
                (!found || mode[i].prio > win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = mode[i].prio;
            end
        end
        for (int i = 0; i < NSRC; i++)
            win_oh[i] = found && (win_idx == IDX_W'(i));
    end

    assert_win_above_R8: assert property (@(posedge clk) disable iff (rst)
        found |-> (!busy || win_prio > cur_lvl));
    assert_one_winner_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_oh) && (found == (|win_oh)));
endmodule

// File: rtl/ixc_nest.sv
module ixc_nest #(
    parameter int DEPTH = 8,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic [2:0]    push_prio,
    input  logic          pop,
    output logic          busy,
    output logic [IW-1:0] top_idx,
    output logic [2:0]    top_prio
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  idx_q  [DEPTH];
    logic [2:0]     prio_q [DEPTH];

    always_comb begin
        top_idx  = '0;
        top_prio = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CW'(i + 1)) begin
                top_idx  = idx_q[i];
                top_prio = prio_q[i];
            end
        end
    end
    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_q[i]  <= '0;
                prio_q[i] <= '0;
            end
        end else if (push && cnt_q < CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_q == CW'(i)) begin
                    idx_q[i]  <= push_idx;
                    prio_q[i] <= push_prio;
                end
            end
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_push_room_R10: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH)));
    assert_pop_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !busy) |=> (cnt_q == '0));
endmodule

// File: rtl/ixc_top.sv
module ixc_top
    import ixc_pkg::*;
#(
    parameter int NSRC   = 50,
    parameter int NDEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_out
);
    localparam int VW = 32;

    logic [IDX_W-1:0] sel_q;
    logic [31:0]      spur_q;
    logic             dbg_q;
    logic             sel_ok;
    logic [NSRC-1:0]  hit;
    cmd_t             cmd;
    logic             cmd_bit;

    mode_t [NSRC-1:0]        mode_q;
    logic [NSRC-1:0][VW-1:0] vec_q;
    logic [NSRC-1:0]         en_q, ff_q, pend, win_oh, ack_oh;
    logic                    found, busy, ack, pop;
    logic [IDX_W-1:0]        win_idx, top_idx;
    logic [2:0]              win_prio, top_prio;
    logic [MAX_SRC-1:0]      pend_full;
    logic [31:0]             sel_mode_w, sel_vec_w, win_vec_w;
    logic                    sel_en_b, sel_ff_b;

    assign sel_ok  = (32'(sel_q) < NSRC);
    assign cmd_bit = bus_wr && bus_wdata[0];

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            hit[i] = sel_ok && (sel_q == IDX_W'(i));
        cmd.en    = cmd_bit && bus_addr == A_EN;
        cmd.dis   = cmd_bit && bus_addr == A_DIS;
        cmd.clr   = cmd_bit && bus_addr == A_CLR;
        cmd.set   = cmd_bit && bus_addr == A_SET;
        cmd.ffen  = cmd_bit && bus_addr == A_FFEN;
        cmd.ffdis = cmd_bit && bus_addr == A_FFDIS;
        cmd.wmode = bus_wr && bus_addr == A_MODE;
        cmd.wvec  = bus_wr && bus_addr == A_VEC;
    end

    assign ack    = bus_rd && (bus_addr == A_CURV) && found;
    assign pop    = bus_wr && (bus_addr == A_EOI);
    assign ack_oh = win_oh & {NSRC{ack}};

    ixc_src_bank #(.NSRC(NSRC), .VW(VW)) u_bank (
        .clk(clk), .rst(rst), .src_in(src_in), .hit(hit), .cmd(cmd),
        .wdata(bus_wdata), .ack_oh(ack_oh), .mode_q(mode_q), .vec_q(vec_q),
        .en_q(en_q), .ff_q(ff_q), .pend(pend)
    );

    ixc_pick #(.NSRC(NSRC)) u_pick (
        .clk(clk), .rst(rst), .req(pend & en_q), .mode(mode_q), .busy(busy),
        .cur_lvl(top_prio), .found(found), .win_oh(win_oh),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    ixc_nest #(.DEPTH(NDEPTH), .IW(IDX_W)) u_nest (
        .clk(clk), .rst(rst), .push(ack), .push_idx(win_idx),
        .push_prio(win_prio), .pop(pop), .busy(busy),
        .top_idx(top_idx), .top_prio(top_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            spur_q <= '0;
            dbg_q  <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_SEL)  sel_q  <= bus_wdata[IDX_W-1:0];
            if (bus_addr == A_SPUR) spur_q <= bus_wdata;
            if (bus_addr == A_DBG)  dbg_q  <= bus_wdata[0];
        end
    end

    always_comb begin
        sel_mode_w = '0;
        sel_vec_w  = '0;
        win_vec_w  = '0;
        sel_en_b   = 1'b0;
        sel_ff_b   = 1'b0;
        pend_full  = '0;
        pend_full[NSRC-1:0] = pend;
        for (int i = 0; i < NSRC; i++) begin
            if (hit[i]) begin
                sel_mode_w = mode_to_word(mode_q[i]);
                sel_vec_w  = vec_q[i];
                sel_en_b   = en_q[i];
                sel_ff_b   = ff_q[i];
            end
            if (win_oh[i]) win_vec_w = vec_q[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SEL:    bus_rdata = {25'd0, sel_q};
            A_MODE:   bus_rdata = sel_mode_w;
            A_VEC:    bus_rdata = sel_vec_w;
            A_CURV:   bus_rdata = found ? win_vec_w : spur_q;
            A_FASTV:  bus_rdata = '0;
            A_CURSRC: bus_rdata = busy ? {25'd0, top_idx} : '0;
            8'h20, 8'h24, 8'h28, 8'h2C:
                      bus_rdata = pend_full[32*bus_addr[3:2] +: 32];
            A_MASK:   bus_rdata = {31'd0, sel_en_b};
            A_CORE:   bus_rdata = {30'd0, busy, found};
            A_SPUR:   bus_rdata = spur_q;
            A_FFSTAT: bus_rdata = {31'd0, sel_ff_b};
            A_DBG:    bus_rdata = {31'd0, dbg_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = found;

    assert_sel_store_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SEL) |=> (sel_q == $past(bus_wdata[IDX_W-1:0])));
    assert_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CURV && !irq_out) |-> (bus_rdata == spur_q));
    assert_out_of_range_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |-> (hit == '0));
endmodule

// File: tb/ixc_top_bench.sv
module ixc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 50;

    logic            clk = 1'b0;
    logic            rst;
    logic            bus_wr, bus_rd;
    logic [7:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_in;
    logic            irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int  pr_m [NSRC];
    bit  en_m [NSRC];
    int  stk_idx [8];
    int  stk_pr  [8];
    int  depth;

    ixc_top #(.NSRC(NSRC), .NDEPTH(8)) u_ixc_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic irqchk(input string req, input logic exp);
        @(negedge clk); #1;
        chk(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    function automatic int pick_model();
        int best = -1;
        for (int i = 0; i < NSRC; i++) begin
            if (src_in[i] && en_m[i] && (depth == 0 || pr_m[i] > stk_pr[depth-1]) &&
                (best < 0 || pr_m[i] > pr_m[best]))
                best = i;
        end
        return best;
    endfunction

    function automatic logic [31:0] vec_model(int i);
        return (i < 0) ? 32'h0000_0BAD : 32'h1000 + 32'(i);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; src_in = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        rdchk("R1 reset index", 8'h00, 32'h0);
        irqchk("R8 reset irq", 1'b0);
        rdchk("R4 reset pending", 8'h20, 32'h0);
        rdchk("R12 reset core", 8'h34, 32'h0);
        rdchk("R9 reset spurious", 8'h10, 32'h0);

        // index register
        wr(8'h00, 32'h1FF);
        rdchk("R1 index width", 8'h00, 32'h7F);

        // out-of-range index
        wr(8'h00, 32'd90);
        wr(8'h04, 32'h63);
        rdchk("R7 mode out of range", 8'h04, 32'h0);
        wr(8'h40, 32'h1);
        rdchk("R7 mask out of range", 8'h30, 32'h0);
        wr(8'h4C, 32'h1);
        rdchk("R7 set out of range", 8'h28, 32'h0);

        // mode / vector per source
        wr(8'h00, 32'd3);
        rdchk("R3 mode reset", 8'h04, 32'h40);
        wr(8'h04, 32'h65);
        rdchk("R3 mode readback", 8'h04, 32'h65);
        wr(8'h08, 32'hABCD);
        rdchk("R3 vector readback", 8'h08, 32'hABCD);
        wr(8'h00, 32'd4);
        rdchk("R3 other vector", 8'h08, 32'h0);

        // enable / disable
        wr(8'h00, 32'd3);
        wr(8'h40, 32'h0);
        rdchk("R2 enable bit0 clear ignored", 8'h30, 32'h0);
        wr(8'h40, 32'h1);
        rdchk("R2 enable", 8'h30, 32'h1);
        wr(8'h00, 32'd4);
        rdchk("R2 neighbour untouched", 8'h30, 32'h0);
        irqchk("R8 no pending no irq", 1'b0);

        // level source 40
        src_in[40] = 1'b1;
        rdchk("R6 level high pending", 8'h24, 32'h100);
        src_in[40] = 1'b0;
        rdchk("R6 level released", 8'h24, 32'h0);

        // rising source 3
        @(negedge clk) src_in[3] = 1'b1;
        @(negedge clk) src_in[3] = 1'b0;
        rdchk("R6 rising latched", 8'h20, 32'h8);
        irqchk("R8 enabled edge raises irq", 1'b1);

        // falling source 5
        wr(8'h00, 32'd5);
        wr(8'h04, 32'h21);
        @(negedge clk) src_in[5] = 1'b1;
        rdchk("R6 falling not on rise", 8'h20, 32'h8);
        @(negedge clk) src_in[5] = 1'b0;
        rdchk("R6 falling latched", 8'h20, 32'h28);

        // clear / set commands
        wr(8'h48, 32'h0);
        rdchk("R5 clear bit0 clear ignored", 8'h20, 32'h28);
        wr(8'h48, 32'h1);
        rdchk("R5 clear", 8'h20, 32'h8);
        wr(8'h00, 32'd33);
        wr(8'h4C, 32'h1);
        rdchk("R5 set", 8'h24, 32'h2);
        rdchk("R4 unimplemented word", 8'h2C, 32'h0);
        wr(8'h48, 32'h1);
        rdchk("R5 clear set source", 8'h24, 32'h0);

        // acknowledge and nesting
        rdchk("R9 ack vector", 8'h10, 32'hABCD);
        irqchk("R9 ack clears edge irq", 1'b0);
        rdchk("R9 ack clears latch", 8'h20, 32'h0);
        rdchk("R9 current source", 8'h18, 32'd3);
        rdchk("R12 core busy", 8'h34, 32'h2);

        wr(8'h00, 32'd4);
        wr(8'h04, 32'h47);
        wr(8'h08, 32'h44);
        wr(8'h40, 32'h1);
        wr(8'h00, 32'd6);
        wr(8'h04, 32'h43);
        wr(8'h40, 32'h1);
        src_in[4] = 1'b1; src_in[6] = 1'b1;
        irqchk("R8 higher priority preempts", 1'b1);
        rdchk("R12 core busy and irq", 8'h34, 32'h3);
        rdchk("R9 nested vector", 8'h10, 32'h44);
        rdchk("R9 nested current", 8'h18, 32'd4);
        irqchk("R8 no source above top", 1'b0);
        wr(8'h38, 32'h0);
        rdchk("R10 pop restores", 8'h18, 32'd3);
        irqchk("R8 level source above restored level", 1'b1);
        for (int k = 0; k < 8; k++) wr(8'h38, 32'h0);
        rdchk("R10 eight pops empty", 8'h18, 32'd0);
        rdchk("R12 core irq only", 8'h34, 32'h1);

        // spurious
        wr(8'h3C, 32'h0BAD);
        wr(8'h44, 32'h1);
        wr(8'h00, 32'd4);
        wr(8'h44, 32'h1);
        src_in[4] = 1'b0; src_in[6] = 1'b0;
        rdchk("R9 spurious vector", 8'h10, 32'h0BAD);
        rdchk("R9 spurious no push", 8'h34, 32'h0);

        // fast force and debug bit
        wr(8'h00, 32'd7);
        wr(8'h50, 32'h1);
        rdchk("R11 fast force set", 8'h58, 32'h1);
        irqchk("R11 fast force no irq", 1'b0);
        wr(8'h54, 32'h1);
        rdchk("R11 fast force clear", 8'h58, 32'h0);
        wr(8'h6C, 32'h1);
        rdchk("R11 debug bit", 8'h6C, 32'h1);

        // restore
        wr(8'h00, 32'd3); wr(8'h44, 32'h1); wr(8'h04, 32'h40);
        wr(8'h00, 32'd5); wr(8'h04, 32'h40);

        // random phase: level-high sources with random priority and enable
        void'($urandom(32'd7));
        for (int i = 0; i < NSRC; i++) begin
            pr_m[i] = int'($urandom_range(0, 7));
            en_m[i] = ($urandom_range(0, 3) != 0);
            wr(8'h00, 32'(i));
            wr(8'h04, 32'h40 | 32'(pr_m[i]));
            wr(8'h08, 32'h1000 + 32'(i));
            wr(en_m[i] ? 8'h40 : 8'h44, 32'h1);
        end
        depth = 0;
        for (int it = 0; it < 40; it++) begin
            int w;
            logic [31:0] d;
            @(negedge clk);
            for (int i = 0; i < NSRC; i++) src_in[i] = ($urandom_range(0, 5) == 0);
            w = pick_model();
            irqchk("R8 random irq", w >= 0);
            for (int k = 0; k < 3; k++) begin
                w = pick_model();
                rd(8'h10, d);
                chk("R8 R9 random ack vector", d, vec_model(w));
                if (w >= 0) begin
                    stk_idx[depth] = w; stk_pr[depth] = pr_m[w]; depth++;
                end
            end
            rdchk("R9 random current", 8'h18, depth > 0 ? 32'(stk_idx[depth-1]) : 32'h0);
            for (int k = 0; k < 8; k++) wr(8'h38, 32'h0);
            depth = 0;
            rdchk("R10 random empty", 8'h18, 32'h0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule